// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sends one free-form command to a serial flash device over a single-line SPI link. Software-side logic sets up an opcode, a length code, eight transmit bytes split across two 32-bit words, two static levels for the spare IO2/IO3 lines, and two option flags. A one-cycle start pulse launches a sequence of chip-select frames. An optional write-enable frame comes first. The instruction frame follows, carrying the opcode and up to eight data bytes. Optional status-poll frames come last and repeat until the device reports that its internal write has finished.

The link is full duplex. While each data byte of the instruction shifts out on IO0, a byte from the device is sampled on IO1. That received byte overwrites the buffer slot the transmit byte came from, so the two output words hold the device's reply after the command. The last status byte read during polling stays visible on its own output. A busy level covers the whole sequence. A one-cycle ready pulse marks its end. Chip-select setup, hold and gap are programmable, and so is the clock idle level.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, csn is 1, io0 is 0, sck equals mode_hi, busy and ready are 0, and io2 and io3 are 1.
- R2: A start accepted in idle raises busy in the next cycle. Every frame follows the same timing. First, csn is low with sck at its idle level for cs_delay+1 cycles. Then each bit takes HALF cycles with sck low, followed by HALF cycles with sck high, and io0 holds the bit for all 2*HALF cycles. Bits go most significant first. After the last bit, csn stays low for cs_delay+1 cycles, then stays high for cs_delay+1 cycles.
- R3: The instruction frame sends opcode and then len_code-1 data bytes. Data byte k is tx_lo[8k+7:8k] for k<4 and tx_hi[8(k-4)+7:8(k-4)] for k>=4. A len_code of 0 acts as 1, and any value above 9 acts as 9.
- R4: With wren_first set, a frame holding only the byte 0x06 comes before the instruction frame.
- R5: With wip_poll set, frames of byte 0x05 followed by a byte with io0 at 0 come after the instruction. These frames repeat as long as bit 0 of the received second byte is 1. The last received status byte appears on status.
- R6: The byte received during data byte k replaces buffer byte k on {rx_hi, rx_lo}. Buffer bytes at or beyond len_code-1 keep the transmit value loaded at start.
- R7: io1 is sampled at the rising sck edge of each bit.
- R8: With mode_hi set, sck idles high. The bit waveform, low half first, is the same as in mode 0.
- R9: busy stays 1 until the sequence ends. ready is then a one-cycle pulse in the first cycle with busy at 0.
- R10: A start while busy has no effect on the waveform, the received data or the timing.
- R11: While busy, io2 and io3 hold io2_lvl and io3_lvl as captured at start. While idle, both are 1.
- R12: A start given in the ready cycle is accepted like any idle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch request |
| mode_hi | input | 1 | Clock idle level: 0 low, 1 high |
| opcode | input | 8 | Instruction opcode |
| len_code | input | 4 | Total bytes in the instruction frame, 1 to 9 |
| tx_lo | input | 32 | Transmit bytes 0 to 3, byte 0 in the low bits |
| tx_hi | input | 32 | Transmit bytes 4 to 7, byte 4 in the low bits |
| io2_lvl | input | 1 | Level held on io2 during the sequence |
| io3_lvl | input | 1 | Level held on io3 during the sequence |
| wren_first | input | 1 | Send a write-enable frame first |
| wip_poll | input | 1 | Poll status until write-in-progress clears |
| cs_delay | input | 8 | Chip-select setup, hold and gap count minus one |
| sck | output | 1 | Serial clock |
| csn | output | 1 | Chip select, active low |
| io0 | output | 1 | Serial data out |
| io1 | input | 1 | Serial data in |
| io2 | output | 1 | Static side line 2 |
| io3 | output | 1 | Static side line 3 |
| rx_lo | output | 32 | Buffer bytes 0 to 3 |
| rx_hi | output | 32 | Buffer bytes 4 to 7 |
| status | output | 8 | Last status byte read |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The ready pulse of one sequence can fall in the same cycle as a new start request. The bench waits for ready and then raises start so that it is sampled at the clock edge that ends the ready cycle. The model marks that cycle as not busy and expects the new sequence's first setup cycle to follow with no gap. A start raised in the middle of a long instruction, carrying a different opcode and different transmit data, is the opposite case. There the model expects no change at all, and the per-cycle waveform comparison together with the final buffer contents decide the outcome.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int WORD_W   = 32;
  localparam int NBYTES   = 2 * WORD_W / 8;
  localparam int MAX_CODE = NBYTES + 1;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_BITS, ST_HOLD, ST_GAP
  } st_e;

  typedef enum logic [1:0] {
    FR_WREN, FR_CMD, FR_POLL
  } fr_e;
endpackage

// File: rtl/fce_half_timer.sv
module fce_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic last_lo,
  output logic last_hi
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HC_END = CW'(HALF - 1);

  logic [CW-1:0] hc;
  logic          wrap;

  assign wrap    = (hc == HC_END);
  assign last_lo = run && !phase_hi && wrap;
  assign last_hi = run && phase_hi && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc       <= '0;
      phase_hi <= 1'b0;
    end else if (!run) begin
      hc       <= '0;
      phase_hi <= 1'b0;
    end else if (wrap) begin
      hc       <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/fce_byte_buf.sv
module fce_byte_buf #(
  parameter int NB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NB*8-1:0]   load_vec,
  input  logic              wr,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_byte,
  output logic [NB*8-1:0]   vec
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [7:0] slot [NB];

  for (genvar k = 0; k < NB; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[k] <= 8'h00;
      else if (load)
        slot[k] <= load_vec[8*k +: 8];
      else if (wr && (wr_idx == IW'(k)))
        slot[k] <= wr_byte;
    end
    assign vec[8*k +: 8] = slot[k];
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_hi,
  input  logic [7:0]       opcode,
  input  logic [3:0]       len_code,
  input  logic [WORD_W-1:0] tx_lo,
  input  logic [WORD_W-1:0] tx_hi,
  input  logic             io2_lvl,
  input  logic             io3_lvl,
  input  logic             wren_first,
  input  logic             wip_poll,
  input  logic [DLY_W-1:0] cs_delay,
  output logic             sck,
  output logic             csn,
  output logic             io0,
  input  logic             io1,
  output logic             io2,
  output logic             io3,
  output logic [WORD_W-1:0] rx_lo,
  output logic [WORD_W-1:0] rx_hi,
  output logic [7:0]       status,
  output logic             busy,
  output logic             ready
);
  localparam int IW = $clog2(NBYTES);

  st_e              st;
  fr_e              fr, fr_nxt;
  logic [DLY_W-1:0] cnt, dly_q;
  logic [7:0]       shreg, opcode_q, status_q, rx_byte, next_in_frame;
  logic             samp, wip_q, cpol_q, lv2_q, lv3_q, ready_q, more;
  logic [2:0]       bitn;
  logic [3:0]       byten, nbytes_q, nb_frame;
  logic             phase_hi, last_lo, last_hi, byte_end, frame_end, buf_wr, accept;
  logic [NBYTES*8-1:0] buf_vec;

  function automatic logic [3:0] clamp_len(input logic [3:0] c);
    if (c == 4'd0)             return 4'd1;
    if (c > 4'(MAX_CODE))      return 4'(MAX_CODE);
    return c;
  endfunction

  function automatic logic [7:0] byte_for(input fr_e f, input logic [3:0] i,
                                          input logic [7:0] op,
                                          input logic [NBYTES*8-1:0] v);
    logic [2:0] di;
    di = 3'(i - 4'd1);
    case (f)
      FR_WREN: return OP_WREN;
      FR_POLL: return (i == 4'd0) ? OP_RDSR : 8'h00;
      default: return (i == 4'd0) ? op : v[{di, 3'b000} +: 8];
    endcase
  endfunction

  fce_half_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st == ST_BITS),
    .phase_hi(phase_hi), .last_lo(last_lo), .last_hi(last_hi)
  );

  assign accept = (st == ST_IDLE) && start;
  assign rx_byte = {shreg[6:0], samp};
  assign byte_end = last_hi && (bitn == 3'd7);
  assign frame_end = byte_end && (byten == nb_frame - 4'd1);
  assign buf_wr = byte_end && (fr == FR_CMD) && (byten != 4'd0);
  assign next_in_frame = byte_for(fr, byten + 4'd1, opcode_q, buf_vec);

  fce_byte_buf #(.NB(NBYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec({tx_hi, tx_lo}),
    .wr(buf_wr), .wr_idx(IW'(byten - 4'd1)), .wr_byte(rx_byte), .vec(buf_vec)
  );

  always_comb begin
    case (fr)
      FR_WREN: begin nb_frame = 4'd1;     more = 1'b1;        fr_nxt = FR_CMD;  end
      FR_POLL: begin nb_frame = 4'd2;     more = status_q[0]; fr_nxt = FR_POLL; end
      default: begin nb_frame = nbytes_q; more = wip_q;       fr_nxt = FR_POLL; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  fr <= FR_CMD;  cnt <= '0;  dly_q <= '0;
      shreg <= 8'h00; opcode_q <= 8'h00; status_q <= 8'h00; samp <= 1'b0;
      wip_q <= 1'b0;  cpol_q <= 1'b0; lv2_q <= 1'b1; lv3_q <= 1'b1;
      ready_q <= 1'b0; bitn <= '0; byten <= '0; nbytes_q <= 4'd1;
    end else begin
      ready_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_SETUP;
          cnt      <= cs_delay;
          dly_q    <= cs_delay;
          fr       <= wren_first ? FR_WREN : FR_CMD;
          shreg    <= wren_first ? OP_WREN : opcode;
          opcode_q <= opcode;
          nbytes_q <= clamp_len(len_code);
          wip_q    <= wip_poll;
          cpol_q   <= mode_hi;
          lv2_q    <= io2_lvl;
          lv3_q    <= io3_lvl;
          bitn     <= '0;
          byten    <= '0;
        end
        ST_SETUP: if (cnt == '0) st <= ST_BITS; else cnt <= cnt - 1'b1;
        ST_BITS: begin
          if (last_lo) samp <= io1;
          if (last_hi) begin
            bitn <= bitn + 1'b1;
            if (byte_end) begin
              if (fr == FR_POLL && byten == 4'd1) status_q <= rx_byte;
              if (frame_end) begin
                st  <= ST_HOLD;
                cnt <= dly_q;
              end else begin
                shreg <= next_in_frame;
                byten <= byten + 1'b1;
              end
            end else begin
              shreg <= rx_byte;
            end
          end
        end
        ST_HOLD: if (cnt == '0) begin
          st  <= ST_GAP;
          cnt <= dly_q;
        end else cnt <= cnt - 1'b1;
        ST_GAP: if (cnt == '0) begin
          if (more) begin
            st    <= ST_SETUP;
            cnt   <= dly_q;
            fr    <= fr_nxt;
            shreg <= byte_for(fr_nxt, 4'd0, opcode_q, buf_vec);
            bitn  <= '0;
            byten <= '0;
          end else begin
            st      <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign ready  = ready_q;
  assign csn    = !((st == ST_SETUP) || (st == ST_BITS) || (st == ST_HOLD));
  assign sck    = (st == ST_BITS) ? phase_hi : (busy ? cpol_q : mode_hi);
  assign io0    = (st == ST_BITS) && shreg[7];
  assign io2    = busy ? lv2_q : 1'b1;
  assign io3    = busy ? lv3_q : 1'b1;
  assign rx_lo  = buf_vec[WORD_W-1:0];
  assign rx_hi  = buf_vec[2*WORD_W-1:WORD_W];
  assign status = status_q;
endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mode_hi,
  input logic busy,
  input logic ready,
  input logic csn,
  input logic sck,
  input logic io0,
  input logic io2,
  input logic io3
);
  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_ready_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (busy || ready));
  p_frame_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csn && !io0));
  p_idle_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == mode_hi));
  p_side_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (io2 && io3));
  p_side_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(io2) && $stable(io3)));
endmodule

bind flash_cmd_engine fce_checker u_fce_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .mode_hi(mode_hi),
  .busy(busy), .ready(ready), .csn(csn), .sck(sck), .io0(io0),
  .io2(io2), .io3(io3)
);

// File: tb/test_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_flash_cmd_engine;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode_hi = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [3:0]  len_code = 4'd1;
  logic [31:0] tx_lo = '0, tx_hi = '0;
  logic        io2_lvl = 1'b0, io3_lvl = 1'b0, wren_first = 1'b0, wip_poll = 1'b0;
  logic [7:0]  cs_delay = 8'd0;
  logic        io1 = 1'b0;
  logic        sck, csn, io0, io2, io3, busy, ready;
  logic [31:0] rx_lo, rx_hi;
  logic [7:0]  status;

  always #10 clk = ~clk;

  flash_cmd_engine #(.HALF(HALF), .DLY_W(8)) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_hi(mode_hi), .opcode(opcode),
    .len_code(len_code), .tx_lo(tx_lo), .tx_hi(tx_hi), .io2_lvl(io2_lvl),
    .io3_lvl(io3_lvl), .wren_first(wren_first), .wip_poll(wip_poll),
    .cs_delay(cs_delay), .sck(sck), .csn(csn), .io0(io0), .io1(io1), .io2(io2),
    .io3(io3), .rx_lo(rx_lo), .rx_hi(rx_hi), .status(status), .busy(busy),
    .ready(ready)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  // expected per cycle: {busy, ready, csn, sck, io0}
  logic [4:0]  exp_q[$];
  logic [71:0] rsp_q[$];
  logic [71:0] cur_rsp = '0;
  int          rises = 0, dly = 0;
  logic        prev_csn = 1'b1, prev_sck = 1'b0, cur_busy = 1'b0, lat2 = 1'b1, lat3 = 1'b1;
  logic [4:0]  last_e = '0;
  logic [63:0] exp_data = '0;
  logic [7:0]  exp_status = 8'h00;

  task automatic tick();
    logic [4:0] e;
    logic e2, e3;
    @(negedge clk);
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else e = {1'b0, 1'b0, 1'b1, mode_hi, 1'b0};
    e2 = e[4] ? lat2 : 1'b1;
    e3 = e[4] ? lat3 : 1'b1;
    n_cmp++;
    if ({busy, ready, csn, sck, io0} !== e || io2 !== e2 || io3 !== e3) begin
      n_bad++;
      $display("FAIL %s cycle: got busy,ready,csn,sck,io0=%b io2/3=%b%b expected %b io2/3=%b%b",
               cur_tag, {busy, ready, csn, sck, io0}, io2, io3, e, e2, e3);
    end
    cur_busy = e[4];
    last_e = e;
    // behavioural flash device: one response frame per chip-select frame
    if (prev_csn && !csn) begin
      cur_rsp = (rsp_q.size() > 0) ? rsp_q.pop_front() : '0;
      rises = 0;
    end else if (!csn && !prev_sck && sck) begin
      rises++;
    end
    if (!csn && rises < 72) io1 = cur_rsp[8*(rises/8) + 7 - (rises%8)];
    else io1 = 1'b0;
    prev_csn = csn;
    prev_sck = sck;
  endtask

  task automatic add_frame(input logic [71:0] fb, input int n);
    for (int c = 0; c <= dly; c++) exp_q.push_back({1'b1, 1'b0, 1'b0, mode_hi, 1'b0});
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        for (int h = 0; h < HALF; h++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b0, fb[8*b+i]});
        for (int h = 0; h < HALF; h++) exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, fb[8*b+i]});
      end
    for (int c = 0; c <= dly; c++) exp_q.push_back({1'b1, 1'b0, 1'b0, mode_hi, 1'b0});
    for (int c = 0; c <= dly; c++) exp_q.push_back({1'b1, 1'b0, 1'b1, mode_hi, 1'b0});
  endtask

  task automatic launch(input logic [7:0] op, input logic [3:0] lc, input logic [31:0] lo,
                        input logic [31:0] hi, input logic l2, input logic l3,
                        input logic wr, input logic wp, input int kbusy,
                        input logic [7:0] seed, input logic [7:0] dl);
    opcode = op; len_code = lc; tx_lo = lo; tx_hi = hi; io2_lvl = l2; io3_lvl = l3;
    wren_first = wr; wip_poll = wp; cs_delay = dl;
    start = 1'b1;
    if (!cur_busy) begin
      int n;
      logic [71:0] fb, rs;
      logic [7:0] st;
      n = (lc == 0) ? 1 : (lc > 9) ? 9 : int'(lc);
      dly = int'(dl); lat2 = l2; lat3 = l3;
      if (wr) begin
        add_frame({64'h0, 8'h06}, 1);
        rsp_q.push_back({9{8'hFF}});
      end
      fb = '0; rs = '0;
      fb[7:0] = op; rs[7:0] = 8'h3C;
      exp_data = {hi, lo};
      for (int k = 1; k < n; k++) begin
        fb[8*k +: 8] = exp_data[8*(k-1) +: 8];
        rs[8*k +: 8] = seed + 8'(k * 19);
      end
      for (int k = 1; k < n; k++) exp_data[8*(k-1) +: 8] = rs[8*k +: 8];
      add_frame(fb, n);
      rsp_q.push_back(rs);
      if (wp)
        for (int p = 0; p <= kbusy; p++) begin
          st = (p < kbusy) ? (8'h01 | 8'(p << 4)) : 8'h42;
          add_frame({56'h0, 8'h00, 8'h05}, 2);
          rsp_q.push_back({56'h0, st, 8'hFF});
          exp_status = st;
        end
      exp_q.push_back({1'b0, 1'b1, 1'b1, mode_hi, 1'b0});
    end
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      tick();
      if (last_e[3]) break;
    end
  endtask

  task automatic check_result(input string tag);
    n_cmp++;
    if ({rx_hi, rx_lo} !== exp_data) begin
      n_bad++;
      $display("FAIL %s R6 buffer: got %h expected %h", tag, {rx_hi, rx_lo}, exp_data);
    end
    n_cmp++;
    if (status !== exp_status) begin
      n_bad++;
      $display("FAIL %s R5 status: got %h expected %h", tag, status, exp_status);
    end
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // R2 R3 R6 R7: plain instruction, four bytes, mode 0
    cur_tag = "R2_R3";
    launch(8'h9F, 4'd4, 32'h44332211, 32'h88776655, 1'b0, 1'b1, 1'b0, 1'b0, 0, 8'hA1, 8'd1);
    wait_done();
    check_result("R6_R7");
    tick(); tick();

    // R4 R3: write-enable first, full nine bytes, zero delay
    cur_tag = "R4";
    launch(8'h02, 4'd9, 32'hDEADBEEF, 32'h01234567, 1'b1, 1'b0, 1'b1, 1'b0, 0, 8'h10, 8'd0);
    wait_done();
    check_result("R4_R6");

    // R5 R11: polling with two busy reads, levels latched
    cur_tag = "R5_R11";
    launch(8'hC7, 4'd1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 8'h00, 8'd2);
    wait_done();
    check_result("R5");
    tick();

    // R8 R10: mode 3, six bytes, ignored start in the middle
    cur_tag = "R8";
    mode_hi = 1'b1;
    tick(); tick();
    launch(8'h4B, 4'd6, 32'hCAFEF00D, 32'h00AA55FF, 1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h77, 8'd1);
    for (int i = 0; i < 60; i++) tick();
    cur_tag = "R10";
    launch(8'hEE, 4'd9, 32'h11111111, 32'h22222222, 1'b0, 1'b0, 1'b1, 1'b1, 0, 8'h00, 8'd5);
    wait_done();
    check_result("R10_R8");
    mode_hi = 1'b0;
    tick(); tick();

    // R12 R9: second start raised in the ready cycle of the first
    cur_tag = "R12";
    launch(8'h35, 4'd2, 32'h000000AB, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 8'h21, 8'd0);
    wait_done();
    launch(8'h05, 4'd3, 32'h0000CDEF, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 0, 8'h55, 8'd1);
    wait_done();
    check_result("R12_R9");

    // R3: length code clamping, 0 acts as 1 and 15 acts as 9
    cur_tag = "R3_len0";
    launch(8'hAB, 4'd0, 32'h12345678, 32'h9ABCDEF0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00, 8'd0);
    wait_done();
    check_result("R3_len0");
    cur_tag = "R3_len15";
    launch(8'hB9, 4'd15, 32'h0F1E2D3C, 32'h4B5A6978, 1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h90, 8'd0);
    wait_done();
    check_result("R3_len15");
    for (int i = 0; i < 4; i++) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule